// File: doc/BRIEF.md
# Bit-Synchronous Frame Transmitter with Check Sequence

This block turns a byte stream into a bit-synchronous HDLC line signal. Bytes arrive on a valid/ready interface with an end-of-frame marker. They leave one bit per transmit slot, marked by a single-cycle enable `bit_en`. Each frame is sent in this order: an opening flag (0x7E), the payload sent least significant bit first with zero-bit insertion, an optional 16-bit frame check sequence, and a closing flag. Between frames the line carries either a continuous mark or back-to-back flags.

Static configuration inputs select the following. The frame check sequence can be turned on or off. The generator polynomial is either the CCITT polynomial x^16+x^12+x^5+1 or the CRC-16 polynomial x^16+x^15+x^2+1. The register can be preset to all ones or all zeros. One further input sets what happens when the byte source runs dry inside a frame: the block either breaks the frame off with an abort, or it closes the frame normally. Whenever that underrun rule is applied, a one-cycle status pulse is raised.

Top module: `hdlc_tx`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `tx_bit` is 1, `in_ready` is 0 and `udrn_pulse` is 0.
- R2: With no frame in progress, `tx_bit` is constantly 1 when `idle_flags`=0. When `idle_flags`=1, it repeats the pattern 0x7E, bit 0 first (0,1,1,1,1,1,1,0).
- R3: A frame is sent as the flag 0x7E (bit 0 first), then each accepted byte bit 0 first. A byte is accepted on a clock where `in_valid` and `in_ready` are both high. `in_ready` is only ever high in a cycle where `bit_en` is high.
- R4: After five consecutive 1 bits of payload or check sequence, one 0 bit is inserted. The run count carries across byte boundaries and from the payload into the check sequence. Flag, abort and idle bits are never stuffed.
- R5: When `crc_on`=0, the closing flag follows the last payload bit directly. When `crc_on`=1, a 16-bit check sequence is sent between them.
- R6: The check register shifts right once per payload bit b. The feedback is `reg[0]^b`, and when the feedback is 1 the shifted value is XORed with 0x8408 (`crc_sel16`=0, CCITT) or 0xA001 (`crc_sel16`=1, CRC-16).
- R7: At the start of each frame the register is set to 0xFFFF when `crc_init_ones`=1 and to 0x0000 when it is 0. The transmitted sequence is the register complemented (preset ones) or taken as is (preset zeros), sent bit 0 first, so the low byte goes out first.
- R8: On an underrun with `udrn_close`=0, the frame ends with 8 consecutive 1 bits. The selected idle state follows, with flags starting at bit 0.
- R9: On an underrun with `udrn_close`=1, the check sequence (if enabled) and a closing flag are sent exactly as at a normal end of frame.
- R10: `udrn_pulse` is high for exactly one clock per underrun. It follows a transmit slot in which a byte was needed and `in_valid` was low.
- R11: `tx_bit` changes only on clock edges where `bit_en` is high. It is updated once per slot.
- R12: A frame waiting in the idle state begins at the next slot when `idle_flags`=0. When `idle_flags`=1 it begins at the first slot that starts a whole idle flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | One transmit bit slot per high cycle |
| in_valid | input | 1 | Byte source has a byte |
| in_data | input | BYTE_W | Payload byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Block takes the byte this cycle |
| crc_on | input | 1 | Append check sequence |
| crc_sel16 | input | 1 | 1 selects CRC-16, 0 selects CCITT |
| crc_init_ones | input | 1 | Preset register to ones (1) or zeros (0) |
| idle_flags | input | 1 | Idle as repeated flags (1) or mark (0) |
| udrn_close | input | 1 | Underrun closes frame (1) or aborts it (0) |
| tx_bit | output | 1 | Serial line bit |
| udrn_pulse | output | 1 | One-cycle underrun indication |

## Verification
The bench uses the default parameters: 8-bit payload, a stuffing run of five and an eight-bit abort. It pulses `bit_en` once every three clocks. With these values, every byte value that holds a run of five ones can be reached in a few bytes. The stuffing run can then be carried across byte boundaries and into the check sequence. Both polynomials and both presets can be reached, and the gap between slots lets the bench see that the line holds still between bit enables. Frames are started both right after reset and in the middle of an idle flag, so the flag-boundary rule shows up as a countable number of idle bits.

// File: rtl/hdlc_tx_pkg.sv
// Shared types and constants for the frame transmitter.
// Assumes a 16-bit check register processed least significant bit first.
package hdlc_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_DATA,
        ST_FCS,
        ST_CLOSE,
        ST_ABORT
    } tx_state_t;

    localparam int          CRC_W      = 16;
    localparam logic [7:0]  FLAG_PAT   = 8'h7E;
    localparam logic [15:0] POLY_CCITT = 16'h8408;  // bit-reversed x^16+x^12+x^5+1
    localparam logic [15:0] POLY_CRC16 = 16'hA001;  // bit-reversed x^16+x^15+x^2+1
endpackage

// File: rtl/hdlc_tx_crc.sv
// Bit-serial check register, shifting right, one payload bit per step.
// Assumes load and step are never high together in the same cycle.
module hdlc_tx_crc
    import hdlc_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             init_ones,
    input  logic             step,
    input  logic             din,
    input  logic             sel16,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] poly;
    logic [CRC_W-1:0] nxt;

    // Pick the polynomial and form the next register value for one bit.
    always_comb begin
        poly = sel16 ? POLY_CRC16 : POLY_CCITT;
        nxt  = (crc >> 1) ^ ((crc[0] ^ din) ? poly : '0);
    end

    // Preset at frame start, advance on each payload bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      crc <= '0;
        else if (load)   crc <= init_ones ? '1 : '0;
        else if (step)   crc <= nxt;
    end
endmodule

// File: rtl/hdlc_tx_stuff.sv
// Counts consecutive stuffable ones on the line and flags when a zero is owed.
// Assumes the owed zero is emitted in the very next slot as a stuffable bit.
module hdlc_tx_stuff #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic stuffable,
    input  logic bitv,
    output logic due
);
    localparam int RW = $clog2(RUN + 1);
    logic [RW-1:0] run_q;

    // Track the run length; any other bit breaks the run.
    always_ff @(posedge clk) begin
        if (!rst_n)                   run_q <= '0;
        else if (adv && stuffable && bitv) run_q <= run_q + RW'(1);
        else if (adv)                 run_q <= '0;
    end

    // A zero is owed once the run reaches its limit.
    always_comb due = (run_q == RW'(RUN));
endmodule

// File: rtl/hdlc_tx.sv
// Frame transmitter: flag, stuffed payload, optional check sequence, flag.
// Assumes bit_en is a single-cycle slot strobe and configuration is static
// during a frame. tx_bit holds the bit chosen at the most recent slot.
module hdlc_tx
    import hdlc_tx_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int STUFF_RUN = 5,
    parameter int ABORT_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              crc_on,
    input  logic              crc_sel16,
    input  logic              crc_init_ones,
    input  logic              idle_flags,
    input  logic              udrn_close,
    output logic              tx_bit,
    output logic              udrn_pulse
);
    localparam int SHW   = (BYTE_W > CRC_W) ? BYTE_W : CRC_W;
    localparam int LW    = $clog2(SHW + 1);
    localparam int CMAX  = (ABORT_LEN > 8) ? ABORT_LEN : 8;
    localparam int CNT_W = $clog2(CMAX);

    tx_state_t        state, nstate;
    logic [CNT_W-1:0] cnt, ncnt;
    logic [SHW-1:0]   shreg, nshreg;
    logic [LW-1:0]    left, nleft;
    logic             last_seen, nlast;
    logic             obit, stuffable, finish, udrn;
    logic             crc_load, crc_step, crc_bit;
    logic             stuff_due;
    logic [CRC_W-1:0] crc_q, fcs;

    hdlc_tx_crc u_crc (
        .clk(clk), .rst_n(rst_n),
        .load(bit_en && crc_load), .init_ones(crc_init_ones),
        .step(bit_en && crc_step), .din(crc_bit), .sel16(crc_sel16),
        .crc(crc_q)
    );

    hdlc_tx_stuff #(.RUN(STUFF_RUN)) u_stuff (
        .clk(clk), .rst_n(rst_n), .adv(bit_en),
        .stuffable(stuffable), .bitv(obit), .due(stuff_due)
    );

    // Byte request: only in a slot that needs a fresh byte.
    always_comb in_ready = bit_en && (state == ST_DATA) && !stuff_due
                           && (left == '0) && !last_seen;

    // Sequence sent after the payload: complemented for a ones preset.
    always_comb fcs = crc_q ^ {CRC_W{crc_init_ones}};

    // Choose the bit for this slot and the state that follows it.
    always_comb begin
        nstate = state;  ncnt = cnt;  nshreg = shreg;  nleft = left;
        nlast = last_seen;  obit = 1'b1;  stuffable = 1'b0;  finish = 1'b0;
        udrn = 1'b0;  crc_load = 1'b0;  crc_step = 1'b0;  crc_bit = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cnt == '0 && in_valid) begin
                    nstate = ST_OPEN;  obit = FLAG_PAT[0];  ncnt = CNT_W'(1);
                    crc_load = 1'b1;   nlast = 1'b0;
                end else if (idle_flags) begin
                    obit = FLAG_PAT[cnt[2:0]];
                    ncnt = (cnt == CNT_W'(7)) ? '0 : cnt + CNT_W'(1);
                end else begin
                    ncnt = '0;
                end
            end
            ST_OPEN: begin
                obit = FLAG_PAT[cnt[2:0]];
                if (cnt == CNT_W'(7)) begin
                    nstate = ST_DATA;  ncnt = '0;  nleft = '0;
                end else begin
                    ncnt = cnt + CNT_W'(1);
                end
            end
            ST_DATA: begin
                if (stuff_due) begin
                    obit = 1'b0;  stuffable = 1'b1;
                end else if (left != '0) begin
                    obit = shreg[0];  nshreg = shreg >> 1;  nleft = left - LW'(1);
                    stuffable = 1'b1;  crc_step = 1'b1;  crc_bit = shreg[0];
                end else if (last_seen) begin
                    finish = 1'b1;
                end else if (in_valid) begin
                    obit = in_data[0];  nshreg = SHW'(in_data) >> 1;
                    nleft = LW'(BYTE_W - 1);  nlast = in_last;
                    stuffable = 1'b1;  crc_step = 1'b1;  crc_bit = in_data[0];
                end else begin
                    udrn = 1'b1;
                    if (udrn_close) begin
                        finish = 1'b1;
                    end else begin
                        nstate = ST_ABORT;  obit = 1'b1;  ncnt = CNT_W'(1);
                    end
                end
            end
            ST_FCS: begin
                if (stuff_due) begin
                    obit = 1'b0;  stuffable = 1'b1;
                end else if (left != '0) begin
                    obit = shreg[0];  nshreg = shreg >> 1;  nleft = left - LW'(1);
                    stuffable = 1'b1;
                end else begin
                    nstate = ST_CLOSE;  obit = FLAG_PAT[0];  ncnt = CNT_W'(1);
                end
            end
            ST_CLOSE: begin
                obit = FLAG_PAT[cnt[2:0]];
                if (cnt == CNT_W'(7)) begin
                    nstate = ST_IDLE;  ncnt = '0;
                end else begin
                    ncnt = cnt + CNT_W'(1);
                end
            end
            default: begin  // ST_ABORT
                obit = 1'b1;
                if (cnt == CNT_W'(ABORT_LEN - 1)) begin
                    nstate = ST_IDLE;  ncnt = '0;
                end else begin
                    ncnt = cnt + CNT_W'(1);
                end
            end
        endcase
        if (finish) begin
            if (crc_on) begin
                nstate = ST_FCS;  obit = fcs[0];  nshreg = SHW'(fcs) >> 1;
                nleft = LW'(CRC_W - 1);  stuffable = 1'b1;
            end else begin
                nstate = ST_CLOSE;  obit = FLAG_PAT[0];  ncnt = CNT_W'(1);
            end
        end
    end

    // Commit the slot decision; the underrun strobe lasts one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  cnt <= '0;  shreg <= '0;  left <= '0;
            last_seen <= 1'b0;  tx_bit <= 1'b1;  udrn_pulse <= 1'b0;
        end else begin
            udrn_pulse <= bit_en && udrn;
            if (bit_en) begin
                state <= nstate;  cnt <= ncnt;  shreg <= nshreg;  left <= nleft;
                last_seen <= nlast;  tx_bit <= obit;
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_check.sv
// Port-level properties of the frame transmitter, bound to every instance.
module hdlc_tx_check (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic in_valid,
    input logic in_ready,
    input logic tx_bit,
    input logic udrn_pulse
);
    assert_reset_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (tx_bit && !udrn_pulse && !in_ready));

    assert_ready_in_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> bit_en);

    assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        udrn_pulse |=> !udrn_pulse);

    assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        udrn_pulse |-> $past(bit_en && !in_valid));

    assert_hold_between_slots_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_bit));
endmodule

bind hdlc_tx hdlc_tx_check u_hdlc_tx_check (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
    .in_ready(in_ready), .tx_bit(tx_bit), .udrn_pulse(udrn_pulse)
);

// File: tb/hdlc_tx_test.sv
// Directed bench: each scenario resets the block, sends one frame and
// compares the captured line against a bit-level model of the requirements.
module hdlc_tx_test;
    localparam int L = 220;

    logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
    logic in_valid, in_last, in_ready, tx_bit, udrn_pulse;
    logic [7:0] in_data;
    logic crc_on = 1'b1, crc_sel16 = 1'b0, crc_init_ones = 1'b1;
    logic idle_flags = 1'b0, udrn_close = 1'b0;

    logic [7:0] src [0:15];
    int  src_n = 0, src_idx = 0;
    logic src_last = 1'b0, src_go = 1'b0, live = 1'b0;
    bit  cap [0:511];
    bit  expv [0:511];
    int  cap_n = 0, exp_n = 0, udrn_cnt = 0, mrun = 0, div = 0;
    int  checks = 0, fails = 0;
    bit  done = 1'b0;

    hdlc_tx uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .crc_on(crc_on), .crc_sel16(crc_sel16), .crc_init_ones(crc_init_ones),
        .idle_flags(idle_flags), .udrn_close(udrn_close),
        .tx_bit(tx_bit), .udrn_pulse(udrn_pulse)
    );

    always #10 clk = ~clk;  // 50 MHz

    assign in_valid = src_go && (src_idx < src_n);
    assign in_data  = src[src_idx[3:0]];
    assign in_last  = src_last && (src_idx == src_n - 1);

    // Byte source advances on each accepted transfer.
    always @(posedge clk) begin
        live <= rst_n;
        if (!rst_n) src_idx <= 0;
        else if (in_valid && in_ready) src_idx <= src_idx + 1;
    end

    // Capture line bits after each slot edge, then drive the next strobe.
    always @(negedge clk) begin
        if (!live) begin
            cap_n = 0;  udrn_cnt = 0;
        end else begin
            if (bit_en && cap_n < 512) begin cap[cap_n] = tx_bit; cap_n = cap_n + 1; end
            if (udrn_pulse) udrn_cnt = udrn_cnt + 1;
        end
        div = (div == 2) ? 0 : div + 1;
        bit_en = (div == 0);
    end

    task automatic check(input string tag, input bit ok, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    function automatic logic [15:0] crc_bit(input logic [15:0] c, input bit b, input bit s16);
        logic fb;
        fb = c[0] ^ b;
        c  = c >> 1;
        if (fb) c = c ^ (s16 ? 16'hA001 : 16'h8408);
        return c;
    endfunction

    task automatic push(input bit b);
        expv[exp_n] = b;  exp_n++;
    endtask

    // Stuffable bit: a zero follows every fifth consecutive one (R4).
    task automatic push_s(input bit b);
        push(b);
        mrun = b ? mrun + 1 : 0;
        if (mrun == 5) begin push(1'b0); mrun = 0; end
    endtask

    task automatic build(input int n, input bit has_last, input int start);
        logic [15:0] c, f;
        int pre;
        exp_n = 0;  mrun = 0;
        pre = idle_flags ? ((start + 7) / 8) * 8 : start;  // R12
        for (int k = 0; k < pre; k++) push(idle_flags ? (k % 8 != 0 && k % 8 != 7) : 1'b1);
        for (int k = 0; k < 8; k++) push(k != 0 && k != 7);
        c = crc_init_ones ? 16'hFFFF : 16'h0000;                     // R7
        for (int i = 0; i < n; i++)
            for (int j = 0; j < 8; j++) begin
                c = crc_bit(c, src[i][j], crc_sel16);                 // R6
                push_s(src[i][j]);
            end
        if (has_last || udrn_close) begin                             // R9
            if (crc_on) begin
                f = c ^ (crc_init_ones ? 16'hFFFF : 16'h0000);
                for (int j = 0; j < 16; j++) push_s(f[j]);
            end
            for (int k = 0; k < 8; k++) push(k != 0 && k != 7);
        end else begin
            for (int k = 0; k < 8; k++) push(1'b1);                   // R8
        end
        for (int k = 0; exp_n < L; k++) push(idle_flags ? (k % 8 != 0 && k % 8 != 7) : 1'b1);
    endtask

    task automatic run_case(input string tag, input bit c_on, input bit s16, input bit ones,
                            input bit flags, input bit close, input int n,
                            input bit has_last, input int start);
        int bad;
        @(negedge clk);
        rst_n = 1'b0;  src_go = 1'b0;
        crc_on = c_on;  crc_sel16 = s16;  crc_init_ones = ones;
        idle_flags = flags;  udrn_close = close;  src_n = n;  src_last = has_last;
        build(n, has_last, start);
        repeat (4) @(negedge clk);
        check({tag, " R1 reset"}, tx_bit === 1'b1 && in_ready === 1'b0 && udrn_pulse === 1'b0,
              int'({tx_bit, in_ready, udrn_pulse}), 4);
        if (start == 0) src_go = 1'b1;
        rst_n = 1'b1;
        if (start > 0) begin wait (cap_n == start); src_go = 1'b1; end
        wait (cap_n == L);
        bad = -1;
        for (int i = 0; i < L; i++) if (bad < 0 && cap[i] !== expv[i]) bad = i;
        if (bad >= 0)
            check({tag, " line bit"}, 1'b0, int'(cap[bad]), int'(expv[bad]));
        else
            check({tag, " line stream"}, 1'b1, 0, 0);
        check({tag, " R3 bytes taken"}, src_idx == n, src_idx, n);
        check({tag, " R10 underrun pulses"}, udrn_cnt == (has_last ? 0 : 1),
              udrn_cnt, has_last ? 0 : 1);
    endtask

    // R1 R3 R6 R7: CCITT, ones preset, mark idle.
    task automatic t_basic;
        src[0] = 8'h01; src[1] = 8'h02; src[2] = 8'h03;
        run_case("R3/R6/R7 basic", 1, 0, 1, 0, 0, 3, 1, 0);
    endtask
    // R4: runs of ones inside and across bytes.
    task automatic t_stuffing;
        src[0] = 8'hFF; src[1] = 8'hFF; src[2] = 8'h7E; src[3] = 8'h1F;
        run_case("R4 stuffing", 1, 0, 1, 0, 0, 4, 1, 0);
    endtask
    // R6 R7 R2: CRC-16, zeros preset, flag idle.
    task automatic t_crc16_zero;
        src[0] = 8'h12; src[1] = 8'h34; src[2] = 8'hF8;
        run_case("R6/R7 crc16 zeros", 1, 1, 0, 1, 0, 3, 1, 0);
    endtask
    // R7: CCITT with zeros preset.
    task automatic t_ccitt_zero;
        src[0] = 8'hA5; src[1] = 8'h5A;
        run_case("R7 ccitt zeros", 1, 0, 0, 0, 0, 2, 1, 0);
    endtask
    // R6 R7: CRC-16 ones preset over a longer payload.
    task automatic t_crc16_ones;
        for (int i = 0; i < 9; i++) src[i] = 8'h31 + 8'(i);
        run_case("R6 crc16 ones", 1, 1, 1, 0, 0, 9, 1, 0);
    endtask
    // R5: no check sequence.
    task automatic t_nocrc;
        src[0] = 8'h3E; src[1] = 8'hFC;
        run_case("R5 no crc", 0, 0, 1, 1, 0, 2, 1, 0);
    endtask
    // R8 R10: abort on underrun, mark idle.
    task automatic t_abort_mark;
        src[0] = 8'hC3; src[1] = 8'hFF;
        run_case("R8 abort mark", 1, 0, 1, 0, 0, 2, 0, 0);
    endtask
    // R8 R2: abort on underrun, flag idle.
    task automatic t_abort_flag;
        src[0] = 8'hF0;
        run_case("R8 abort flags", 1, 1, 0, 1, 0, 1, 0, 0);
    endtask
    // R9 R10: underrun closes the frame with sequence and flag.
    task automatic t_close;
        src[0] = 8'h81; src[1] = 8'h7F;
        run_case("R9 underrun close", 1, 1, 1, 1, 1, 2, 0, 0);
    endtask
    // R12 R2: frame arrives mid-flag, waits for the boundary.
    task automatic t_late_flag;
        src[0] = 8'h55;
        run_case("R12 late start flags", 1, 0, 1, 1, 0, 1, 1, 11);
    endtask
    // R12: with mark idle the frame starts in the very next slot.
    task automatic t_late_mark;
        src[0] = 8'hE7;
        run_case("R12 late start mark", 0, 0, 1, 0, 0, 1, 1, 5);
    endtask

    initial begin
        t_basic;  t_stuffing;  t_crc16_zero;  t_ccitt_zero;  t_crc16_ones;
        t_nocrc;  t_abort_mark;  t_abort_flag;  t_close;  t_late_flag;  t_late_mark;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            checks++;  fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule